// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block chooses the power-saving state a processor enters when it executes a wait-for-interrupt (WFI) or wait-for-event (WFE) instruction. It then holds that state until a valid wakeup arrives. Three control bits pick the state. A deep-sleep select bit chooses between a light state that only gates the CPU clock and the deeper states. A power-down select bit chooses, among the deeper states, between one that gates clocks and one that removes core-domain power. A regulator select bit puts the supply in its low-power setting while clocks are stopped.

Each state drives its own set of outputs: CPU clock enable, core-domain clock enable, internal and external oscillator enables, regulator on and low-power controls, and the core-domain power switch. Each state also accepts its own wakeup sources. The light and clock-stopped states resume execution without a reset. Leaving the clock-stopped state first re-enables the internal oscillator and waits for it to report ready. The powered-off state can only be left through a full system reset request, and that exit raises a sticky flag. A sleep-on-exit option drops into the light state when the last interrupt handler returns.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_o` is 0 (Run). CPU and core clocks, both oscillators, the regulator and core power are on. `reg_lp_o`, `sys_rst_req_o` and `standby_flag_o` are low.
- R2: In Run, a WFI or WFE pulse with `cfg_deep_i` low enters Sleep (`mode_o`=1) on the next edge. The power-down and regulator bits have no effect. Only `cpu_clk_en_o` drops; every other clock, oscillator and supply stays on.
- R3: Sleep entered by WFI leaves to Run when `irq_pend_i` is high. Sleep entered by WFE ignores `irq_pend_i` and leaves only when `wake_evt_i` is high. If WFI and WFE arrive together, the entry counts as WFI.
- R4: WFI or WFE with `cfg_deep_i` high and `cfg_pdown_i` low enters Stop (`mode_o`=2). Core clocks and both oscillators are off and the regulator stays on. `reg_lp_o` equals `cfg_lpreg_i` as sampled at entry.
- R5: Stop is left only when some `ext_line_i` bit is high while its `ext_mask_i` bit is high, or when some `rx_wake_i` bit is high. Interrupts, events and masked lines are ignored.
- R6: On leaving Stop, `hsi_en_o` turns on while the core clocks stay off and `mode_o` stays 2. Run resumes on the edge that ends `SETTLE_CYC` consecutive cycles of `osc_rdy_i` high. With the default of 4 and ready already high, core clocks return 4 edges after the wake edge.
- R7: WFI or WFE with both `cfg_deep_i` and `cfg_pdown_i` high enters Standby (`mode_o`=3). All clocks and oscillators, the regulator and core power are off, and `reg_lp_o` is low.
- R8: Standby is left only on a rising edge of `wkup_pin_i`, `rtc_alarm_i`, `ext_rst_i` or `wdog_rst_i`. A wakeup pin that is already high at entry does not wake the block. Interrupts, events, external lines and receive wakeups have no effect.
- R9: Leaving Standby raises `sys_rst_req_o` for exactly one cycle and then returns to Run. `standby_flag_o` goes high and stays high until `rst_n`.
- R10: Leaving Sleep or Stop never raises `sys_rst_req_o` and leaves `standby_flag_o` unchanged.
- R11: With `cfg_sleep_on_exit_i` high, an `isr_exit_last_i` pulse in Run enters Sleep whatever the deep-sleep bit says, and Sleep then wakes on `irq_pend_i`. With the option low, the pulse has no effect.
- R12: `wkup_pin_i` passes through a two-flop synchroniser and an edge detector. After the pin rises ahead of edge k, `sys_rst_req_o` is high after edge k+2 and low before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low power/system reset |
| cfg_deep_i | input | 1 | Deep-sleep select |
| cfg_pdown_i | input | 1 | Power-down select for deep sleep |
| cfg_lpreg_i | input | 1 | Low-power regulator select for Stop |
| cfg_sleep_on_exit_i | input | 1 | Enter Sleep on return from last handler |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| isr_exit_last_i | input | 1 | Return from last interrupt handler strobe |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| wake_evt_i | input | 1 | Wakeup event |
| ext_line_i | input | N_EXT | External interrupt/event lines |
| ext_mask_i | input | N_EXT | Per-line wakeup enable |
| rx_wake_i | input | N_RX | Serial peripheral receive-wakeup requests |
| wkup_pin_i | input | 1 | Asynchronous wakeup pin |
| rtc_alarm_i | input | 1 | RTC alarm |
| ext_rst_i | input | 1 | External reset pin asserted |
| wdog_rst_i | input | 1 | Independent watchdog reset |
| osc_rdy_i | input | 1 | Internal oscillator ready |
| mode_o | output | 2 | 0 Run, 1 Sleep, 2 Stop, 3 Standby |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| core_clk_en_o | output | 1 | Core-domain clock enable |
| hsi_en_o | output | 1 | Internal high-speed oscillator enable |
| hse_en_o | output | 1 | External high-speed oscillator enable |
| reg_on_o | output | 1 | Regulator enabled |
| reg_lp_o | output | 1 | Regulator in low-power setting |
| core_pwr_on_o | output | 1 | Core-domain power switch |
| sys_rst_req_o | output | 1 | System reset request on Standby exit |
| standby_flag_o | output | 1 | Sticky flag: last wake was from Standby |

## Verification
The bench tries wake sources that belong to another state. A design that mixed up the sets would leave Stop on an interrupt, or leave WFE-Sleep on an interrupt, or leave Standby on a receive wakeup. It holds the wakeup pin high across Standby entry, where a level-sensitive detector would wake at once. It also counts the settle edges after Stop with the ready line held low and then high; an off-by-one counter would ungate the core clocks a cycle early or late. It counts reset-request cycles on every exit, which catches a reset that is missing, lasts longer than one cycle, or fires on Sleep or Stop exits.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_STOP, ST_STOP_WAKE, ST_STANDBY, ST_STBY_EXIT
  } lp_state_e;

  typedef struct packed {
    logic cpu_clk;
    logic core_clk;
    logic hsi;
    logic hse;
    logic reg_on;
    logic reg_lp;
    logic pwr_on;
    logic rst_req;
  } lp_ctl_t;

  // Low-power state selected by the control bits at entry.
  function automatic lp_state_e pick_target(input logic deep, input logic pdown);
    if (!deep)      return ST_SLEEP;
    else if (pdown) return ST_STANDBY;
    else            return ST_STOP;
  endfunction

  // Reported mode code: 0 Run, 1 Sleep, 2 Stop, 3 Standby.
  function automatic logic [1:0] state_to_mode(input lp_state_e s);
    case (s)
      ST_SLEEP:                 return 2'd1;
      ST_STOP, ST_STOP_WAKE:    return 2'd2;
      ST_STANDBY, ST_STBY_EXIT: return 2'd3;
      default:                  return 2'd0;
    endcase
  endfunction

  // Clock and power policy per state.
  function automatic lp_ctl_t state_ctl(input lp_state_e s, input logic lp_sel);
    lp_ctl_t c;
    c = '{cpu_clk: 1'b1, core_clk: 1'b1, hsi: 1'b1, hse: 1'b1,
          reg_on: 1'b1, reg_lp: 1'b0, pwr_on: 1'b1, rst_req: 1'b0};
    case (s)
      ST_SLEEP: c.cpu_clk = 1'b0;
      ST_STOP: begin
        c.cpu_clk = 1'b0; c.core_clk = 1'b0; c.hsi = 1'b0; c.hse = 1'b0;
        c.reg_lp = lp_sel;
      end
      ST_STOP_WAKE: begin
        c.cpu_clk = 1'b0; c.core_clk = 1'b0; c.hse = 1'b0;
      end
      ST_STANDBY: begin
        c.cpu_clk = 1'b0; c.core_clk = 1'b0; c.hsi = 1'b0; c.hse = 1'b0;
        c.reg_on = 1'b0; c.pwr_on = 1'b0;
      end
      ST_STBY_EXIT: begin
        c.cpu_clk = 1'b0; c.core_clk = 1'b0; c.hse = 1'b0;
        c.rst_req = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

  // Counter width able to hold values 0 .. n-1.
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lp_wkpin_sync.sv
module lp_wkpin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  // SYNC_STAGES synchroniser flops plus one history flop for edge detection.
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/lp_osc_settle.sv
module lp_osc_settle #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic rdy_i,
  output logic done_o
);
  localparam int CW = lp_pkg::cnt_w(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = active_i & rdy_i & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (!active_i || !rdy_i || done_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_deep_i,
  input  logic      cfg_pdown_i,
  input  logic      cfg_lpreg_i,
  input  logic      wfi_i,
  input  logic      wfe_i,
  input  logic      soe_req_i,
  input  logic      irq_pend_i,
  input  logic      wake_evt_i,
  input  logic      stop_wake_i,
  input  logic      settle_done_i,
  input  logic      stby_wake_i,
  output lp_state_e state_o,
  output logic      lp_sel_o,
  output logic      flag_o
);
  lp_state_e state_q, state_d;
  logic      by_wfe_q, by_wfe_d;
  logic      lp_q, lp_d;
  logic      flag_q;

  always_comb begin
    state_d  = state_q;
    by_wfe_d = by_wfe_q;
    lp_d     = lp_q;
    case (state_q)
      ST_RUN: begin
        if (wfi_i || wfe_i) begin
          state_d  = pick_target(cfg_deep_i, cfg_pdown_i);
          by_wfe_d = wfe_i & ~wfi_i;
          lp_d     = cfg_lpreg_i;
        end else if (soe_req_i) begin
          state_d  = ST_SLEEP;
          by_wfe_d = 1'b0;
        end
      end
      ST_SLEEP: begin
        if (by_wfe_q ? wake_evt_i : irq_pend_i) state_d = ST_RUN;
      end
      ST_STOP:      if (stop_wake_i)   state_d = ST_STOP_WAKE;
      ST_STOP_WAKE: if (settle_done_i) state_d = ST_RUN;
      ST_STANDBY:   if (stby_wake_i)   state_d = ST_STBY_EXIT;
      ST_STBY_EXIT: state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      by_wfe_q <= 1'b0;
      lp_q     <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      by_wfe_q <= by_wfe_d;
      lp_q     <= lp_d;
      if (state_q == ST_STBY_EXIT) flag_q <= 1'b1;
    end
  end

  assign state_o  = state_q;
  assign lp_sel_o = lp_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_pkg::*;
#(
  parameter int N_EXT       = 8,
  parameter int N_RX        = 2,
  parameter int SETTLE_CYC  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_deep_i,
  input  logic             cfg_pdown_i,
  input  logic             cfg_lpreg_i,
  input  logic             cfg_sleep_on_exit_i,
  input  logic             wfi_i,
  input  logic             wfe_i,
  input  logic             isr_exit_last_i,
  input  logic             irq_pend_i,
  input  logic             wake_evt_i,
  input  logic [N_EXT-1:0] ext_line_i,
  input  logic [N_EXT-1:0] ext_mask_i,
  input  logic [N_RX-1:0]  rx_wake_i,
  input  logic             wkup_pin_i,
  input  logic             rtc_alarm_i,
  input  logic             ext_rst_i,
  input  logic             wdog_rst_i,
  input  logic             osc_rdy_i,
  output logic [1:0]       mode_o,
  output logic             cpu_clk_en_o,
  output logic             core_clk_en_o,
  output logic             hsi_en_o,
  output logic             hse_en_o,
  output logic             reg_on_o,
  output logic             reg_lp_o,
  output logic             core_pwr_on_o,
  output logic             sys_rst_req_o,
  output logic             standby_flag_o
);
  // Named internal events, also observed by the bound checker.
  logic      pin_rise;
  logic      stop_wake;
  logic      stby_wake;
  logic      soe_req;
  logic      entry_req;
  logic      settle_done;
  logic      in_settle;
  logic      lp_sel;
  lp_state_e state;
  lp_ctl_t   ctl;

  assign stop_wake = (|(ext_line_i & ext_mask_i)) | (|rx_wake_i);
  assign stby_wake = pin_rise | rtc_alarm_i | ext_rst_i | wdog_rst_i;
  assign soe_req   = cfg_sleep_on_exit_i & isr_exit_last_i;
  assign entry_req = wfi_i | wfe_i | soe_req;
  assign in_settle = (state == ST_STOP_WAKE);

  lp_wkpin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (wkup_pin_i),
    .rise_o (pin_rise)
  );

  lp_osc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (in_settle),
    .rdy_i    (osc_rdy_i),
    .done_o   (settle_done)
  );

  lp_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_deep_i    (cfg_deep_i),
    .cfg_pdown_i   (cfg_pdown_i),
    .cfg_lpreg_i   (cfg_lpreg_i),
    .wfi_i         (wfi_i),
    .wfe_i         (wfe_i),
    .soe_req_i     (soe_req),
    .irq_pend_i    (irq_pend_i),
    .wake_evt_i    (wake_evt_i),
    .stop_wake_i   (stop_wake),
    .settle_done_i (settle_done),
    .stby_wake_i   (stby_wake),
    .state_o       (state),
    .lp_sel_o      (lp_sel),
    .flag_o        (standby_flag_o)
  );

  always_comb ctl = state_ctl(state, lp_sel);

  assign mode_o        = state_to_mode(state);
  assign cpu_clk_en_o  = ctl.cpu_clk;
  assign core_clk_en_o = ctl.core_clk;
  assign hsi_en_o      = ctl.hsi;
  assign hse_en_o      = ctl.hse;
  assign reg_on_o      = ctl.reg_on;
  assign reg_lp_o      = ctl.reg_lp;
  assign core_pwr_on_o = ctl.pwr_on;
  assign sys_rst_req_o = ctl.rst_req;
endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       cpu_clk_en,
  input logic       core_clk_en,
  input logic       hse_en,
  input logic       reg_on,
  input logic       core_pwr_on,
  input logic       sys_rst_req,
  input logic       standby_flag,
  input logic       osc_rdy,
  input logic       settle_done,
  input logic       entry_req
);
  // R2
  cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |-> !cpu_clk_en);

  // R4
  stop_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!core_clk_en && !hse_en));

  // R7
  standby_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !sys_rst_req) |-> (!core_pwr_on && !reg_on));

  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> standby_flag);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby_flag |=> standby_flag);

  // R6
  settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && mode == 2'd0) |-> $past(settle_done));

  // R6
  settle_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |-> osc_rdy);

  // R11
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd0 && mode != 2'd0) |-> $past(entry_req));

  // R10
  no_rst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3) |-> !sys_rst_req);
endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode_o),
  .cpu_clk_en   (cpu_clk_en_o),
  .core_clk_en  (core_clk_en_o),
  .hse_en       (hse_en_o),
  .reg_on       (reg_on_o),
  .core_pwr_on  (core_pwr_on_o),
  .sys_rst_req  (sys_rst_req_o),
  .standby_flag (standby_flag_o),
  .osc_rdy      (osc_rdy_i),
  .settle_done  (settle_done),
  .entry_req    (entry_req)
);

// File: tb/tb_lp_mode_ctrl.sv
`timescale 1ns/1ps
module tb_lp_mode_ctrl;
  localparam int N_EXT = 8;
  localparam int N_RX  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_deep_i = 0, cfg_pdown_i = 0, cfg_lpreg_i = 0, cfg_sleep_on_exit_i = 0;
  logic wfi_i = 0, wfe_i = 0, isr_exit_last_i = 0, irq_pend_i = 0, wake_evt_i = 0;
  logic [N_EXT-1:0] ext_line_i = '0, ext_mask_i = '0;
  logic [N_RX-1:0]  rx_wake_i = '0;
  logic wkup_pin_i = 0, rtc_alarm_i = 0, ext_rst_i = 0, wdog_rst_i = 0, osc_rdy_i = 1;
  logic [1:0] mode_o;
  logic cpu_clk_en_o, core_clk_en_o, hsi_en_o, hse_en_o, reg_on_o, reg_lp_o;
  logic core_pwr_on_o, sys_rst_req_o, standby_flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lp_mode_ctrl #(.N_EXT(N_EXT), .N_RX(N_RX), .SETTLE_CYC(4), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_deep_i(cfg_deep_i), .cfg_pdown_i(cfg_pdown_i), .cfg_lpreg_i(cfg_lpreg_i),
    .cfg_sleep_on_exit_i(cfg_sleep_on_exit_i),
    .wfi_i(wfi_i), .wfe_i(wfe_i), .isr_exit_last_i(isr_exit_last_i),
    .irq_pend_i(irq_pend_i), .wake_evt_i(wake_evt_i),
    .ext_line_i(ext_line_i), .ext_mask_i(ext_mask_i), .rx_wake_i(rx_wake_i),
    .wkup_pin_i(wkup_pin_i), .rtc_alarm_i(rtc_alarm_i), .ext_rst_i(ext_rst_i),
    .wdog_rst_i(wdog_rst_i), .osc_rdy_i(osc_rdy_i),
    .mode_o(mode_o), .cpu_clk_en_o(cpu_clk_en_o), .core_clk_en_o(core_clk_en_o),
    .hsi_en_o(hsi_en_o), .hse_en_o(hse_en_o), .reg_on_o(reg_on_o), .reg_lp_o(reg_lp_o),
    .core_pwr_on_o(core_pwr_on_o), .sys_rst_req_o(sys_rst_req_o),
    .standby_flag_o(standby_flag_o)
  );

  // Output word: {cpu, core, hsi, hse, reg_lp, reg_on, pwr}
  localparam logic [6:0] RUN_WORD = 7'b1111011;
  function automatic logic [6:0] out_word();
    return {cpu_clk_en_o, core_clk_en_o, hsi_en_o, hse_en_o, reg_lp_o, reg_on_o, core_pwr_on_o};
  endfunction

  // Entry vectors: {deep, pdown, lpreg, use_wfe, mode[1:0], word[6:0]}
  localparam logic [12:0] VEC [6] = '{
    13'b0000_01_0111011,
    13'b0111_01_0111011,
    13'b1000_10_0000011,
    13'b1011_10_0000111,
    13'b1100_11_0000000,
    13'b1111_11_0000000
  };

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic enter(input logic deep, input logic pd, input logic lp, input logic use_wfe);
    cfg_deep_i = deep; cfg_pdown_i = pd; cfg_lpreg_i = lp;
    if (use_wfe) wfe_i = 1; else wfi_i = 1;
    tick();
    wfi_i = 0; wfe_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rst_cnt;
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1", "mode", mode_o, 0);
    check("R1", "outputs", out_word(), RUN_WORD);
    check("R1", "rst/flag", {sys_rst_req_o, standby_flag_o}, 2'b00);

    // Table walk: R2 R4 R7 entry policy, then wake with all sources
    foreach (VEC[i]) begin
      enter(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9]);
      check("R2/R4/R7", $sformatf("vec%0d mode", i), mode_o, VEC[i][8:7]);
      check("R2/R4/R7", $sformatf("vec%0d outputs", i), out_word(), VEC[i][6:0]);
      irq_pend_i = 1; wake_evt_i = 1; ext_line_i = 1; ext_mask_i = 1; rtc_alarm_i = 1;
      rst_cnt = 0;
      tick();
      irq_pend_i = 0; wake_evt_i = 0; ext_line_i = 0; ext_mask_i = 0; rtc_alarm_i = 0;
      for (int k = 0; k < 10; k++) begin
        if (sys_rst_req_o) rst_cnt++;
        tick();
      end
      check("R9/R10", $sformatf("vec%0d reset cycles", i), rst_cnt, (VEC[i][8:7] == 2'd3) ? 1 : 0);
      check("R2", $sformatf("vec%0d back to run", i), mode_o, 0);
    end
    check("R9", "flag after standby exit", standby_flag_o, 1);

    // R3 WFE-sleep ignores interrupts
    enter(0, 0, 0, 1);
    irq_pend_i = 1; tick(2); irq_pend_i = 0;
    check("R3", "wfe sleep ignores irq", mode_o, 1);
    wake_evt_i = 1; tick(); wake_evt_i = 0;
    check("R3", "wfe sleep wakes on event", mode_o, 0);
    // R3 WFI-sleep ignores event, wakes on irq; WFI wins over WFE
    cfg_deep_i = 0; wfi_i = 1; wfe_i = 1; tick(); wfi_i = 0; wfe_i = 0;
    wake_evt_i = 1; tick(); wake_evt_i = 0;
    check("R3", "wfi sleep ignores event", mode_o, 1);
    irq_pend_i = 1; tick(); irq_pend_i = 0;
    check("R3", "wfi sleep wakes on irq", mode_o, 0);

    // R5 Stop ignores irq, events and masked lines; rx wake exits
    enter(1, 0, 1, 0);
    irq_pend_i = 1; wake_evt_i = 1; ext_line_i = 8'hF0; ext_mask_i = 8'h0F;
    tick(3);
    irq_pend_i = 0; wake_evt_i = 0; ext_line_i = 0; ext_mask_i = 0;
    check("R5", "stop ignores non-wake inputs", mode_o, 2);
    check("R4", "reg_lp held", reg_lp_o, 1);
    // R6 settle with ready low then high
    osc_rdy_i = 0; rx_wake_i = 2'b10; tick(); rx_wake_i = 0;
    check("R6", "settle hsi on", {hsi_en_o, core_clk_en_o, mode_o}, {1'b1, 1'b0, 2'd2});
    tick(5);
    check("R6", "waits for ready", {core_clk_en_o, mode_o}, {1'b0, 2'd2});
    osc_rdy_i = 1; tick(3);
    check("R6", "3 ready cycles not enough", core_clk_en_o, 0);
    tick();
    check("R6", "run after 4 ready cycles", {core_clk_en_o, mode_o}, {1'b1, 2'd0});
    // R6 default timing with ready already high, ext line exit, R10 no reset
    enter(1, 0, 0, 1);
    ext_line_i = 8'h04; ext_mask_i = 8'h04; rst_cnt = 0; tick();
    ext_line_i = 0; ext_mask_i = 0;
    for (int k = 0; k < 3; k++) begin
      if (sys_rst_req_o) rst_cnt++;
      tick();
    end
    check("R6", "clocks still gated at edge 3", core_clk_en_o, 0);
    tick();
    check("R6", "clocks at edge 4", core_clk_en_o, 1);
    check("R10", "no reset on stop exit", rst_cnt, 0);
    check("R10", "flag unchanged", standby_flag_o, 1);

    // R8 R12 Standby: pin high at entry, other sources ignored
    wkup_pin_i = 1; tick(4);
    enter(1, 1, 0, 0);
    irq_pend_i = 1; wake_evt_i = 1; ext_line_i = '1; ext_mask_i = '1; rx_wake_i = '1;
    tick(4);
    irq_pend_i = 0; wake_evt_i = 0; ext_line_i = 0; ext_mask_i = 0; rx_wake_i = 0;
    check("R8", "standby ignores level pin and others", {mode_o, sys_rst_req_o}, {2'd3, 1'b0});
    wkup_pin_i = 0; tick(4);
    check("R8", "pin fall no wake", {mode_o, sys_rst_req_o}, {2'd3, 1'b0});
    wkup_pin_i = 1; tick(2);
    check("R12", "no reset before edge k+2", sys_rst_req_o, 0);
    tick();
    check("R12", "reset after edge k+2", sys_rst_req_o, 1);
    tick();
    check("R9", "one-cycle reset then run", {sys_rst_req_o, mode_o, standby_flag_o}, {1'b0, 2'd0, 1'b1});
    wkup_pin_i = 0;

    // R8 watchdog and external reset exits
    enter(1, 1, 1, 1);
    wdog_rst_i = 1; tick(); wdog_rst_i = 0;
    check("R8", "wdog exit", {mode_o, sys_rst_req_o}, {2'd3, 1'b1});
    tick();
    check("R8", "wdog back to run", mode_o, 0);
    enter(1, 1, 0, 0);
    ext_rst_i = 1; tick(); ext_rst_i = 0;
    check("R8", "ext reset exit", sys_rst_req_o, 1);
    tick();

    // R11 sleep-on-exit
    cfg_deep_i = 1; cfg_pdown_i = 1; cfg_sleep_on_exit_i = 0;
    isr_exit_last_i = 1; tick(); isr_exit_last_i = 0;
    check("R11", "option off no entry", mode_o, 0);
    cfg_sleep_on_exit_i = 1;
    isr_exit_last_i = 1; tick(); isr_exit_last_i = 0;
    check("R11", "enters sleep", {mode_o, cpu_clk_en_o, core_clk_en_o}, {2'd1, 1'b0, 1'b1});
    irq_pend_i = 1; tick(); irq_pend_i = 0;
    check("R11", "wakes on irq", mode_o, 0);
    cfg_sleep_on_exit_i = 0;

    // R9 flag clears only on reset
    rst_n = 0; tick(); rst_n = 1; tick();
    check("R9", "flag cleared by reset", standby_flag_o, 0);
    check("R1", "run after second reset", out_word(), RUN_WORD);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule